// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block sits beside a memory management unit and keeps a record of access faults. Whenever the fault strobe fires, it takes the faulting address and four qualifiers: write, instruction fetch, alternate-address-space access and supervisor mode. It then updates a fault status register and a fault address register. If a second fault arrives before software has read the status, the block keeps a sticky overflow mark so that software can tell a fault was lost.

The block also decides whether the fault becomes a data-access trap to the core. The trap is taken only when the MMU is enabled and the no-fault control bit is clear. The fault is recorded in both registers whatever the control bits say.

Software uses a small read port. Reading the status register returns its value and clears it. Reading the address register has no side effect. A fault that lands in the same cycle as a status read wins over the clear: it is recorded as if the register had already been emptied.

Top module: `mmu_fault_capture`

## Requirements
- R1: A synchronous active-high reset clears the status register, the address register and the trap output to zero.
- R2: A fault that lands on a zero status register, with no status read in the same cycle, gives this status: value 5 in bits 4:2, bit 1 set (address valid), bit 0 clear, and the qualifier bits of R4.
- R3: A fault that lands on a nonzero status register, with no status read in the same cycle, replaces the old contents with 1, so bit 0 marks overflow. The new fault's bits from R2 and R4 are then ORed in.
- R4: The qualifier bits of the status register are: bit 16 for an alternate-space access, bit 5 for supervisor mode, bit 6 for an instruction fetch and bit 7 for a write. A qualifier that is low leaves its bit clear.
- R5: Every fault loads the full faulting address into the address register, whatever the control bits and the status are.
- R6: The trap output goes high for exactly the one cycle after a fault strobe, and only when the enable input is 1 and the no-fault input is 0. Otherwise it stays low.
- R7: A read with select 0 returns the status register in the same cycle and clears it to zero at the next clock edge. A read with select 1 returns the address register zero-extended and changes nothing.
- R8: When a fault and a status read happen in the same cycle, the read returns the old value. The register then holds only the new fault's bits, with bit 0 clear.
- R9: With no fault and no status read, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault strobe, one cycle per fault |
| flt_addr | input | AW | Faulting address |
| flt_write | input | 1 | Fault came from a write |
| flt_fetch | input | 1 | Fault came from an instruction fetch |
| flt_alt | input | 1 | Fault came from an alternate-space access |
| flt_super | input | 1 | Faulting access was made in supervisor mode |
| ctl_enable | input | 1 | MMU enable control bit |
| ctl_nofault | input | 1 | No-fault control bit, which suppresses the trap |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read select: 0 for status (read clears it), 1 for address |
| rd_data | output | DW | Read data, DW is the larger of AW and SW |
| trap_pulse | output | 1 | Data-access trap request, one cycle wide |

## Verification
On every cycle the assertions check several things:
- After each fault, the address-valid bit and the fault type are present.
- Overflow is marked when a fault hits a nonzero status with no read in the same cycle.
- A read with no fault clears the status to zero, and the status holds when idle.
- The address register follows each fault.
- The trap fires exactly when the gating allows it.

The bench scenarios show the exact values:
- the full status word for each mix of qualifiers;
- the value a read returns in the same cycle;
- the fault-over-clear priority when a fault and a status read coincide;
- that an address read leaves both registers untouched.

// File: rtl/mmu_flt_pkg.sv
package mmu_flt_pkg;

    localparam int OVF_BIT   = 0;
    localparam int AV_BIT    = 1;
    localparam int FT_LSB    = 2;
    localparam int FT_W      = 3;
    localparam int SUP_BIT   = 5;
    localparam int FETCH_BIT = 6;
    localparam int WR_BIT    = 7;
    localparam int ALT_BIT   = 16;
    localparam int MIN_SW    = ALT_BIT + 1;

    localparam logic [FT_W-1:0] FT_ACCESS_ERR = 3'd5;

    typedef struct packed {
        logic write;
        logic fetch;
        logic alt;
        logic super_mode;
    } flt_qual_t;

endpackage

// File: rtl/mmu_flt_status.sv
module mmu_flt_status
    import mmu_flt_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flt_valid,
    input  flt_qual_t     qual,
    input  logic          clr,
    output logic [SW-1:0] st_q
);

    typedef struct packed {
        logic [SW-1:0] st;
    } st_state_t;

    st_state_t s_d, s_q;
    logic [SW-1:0] base;
    logic [SW-1:0] new_bits;

    // Status bits contributed by the incoming fault.
    always_comb begin
        new_bits = '0;
        new_bits[AV_BIT] = 1'b1;
        new_bits[FT_LSB +: FT_W] = FT_ACCESS_ERR;
        new_bits[SUP_BIT] = qual.super_mode;
        new_bits[FETCH_BIT] = qual.fetch;
        new_bits[WR_BIT] = qual.write;
        new_bits[ALT_BIT] = qual.alt;
    end

    // Next-state logic. A fault wins over a clear: a read-clear first
    // empties the register, then any fault lands on what is left.
    always_comb begin
        s_d = s_q;
        base = clr ? '0 : s_q.st;
        if (flt_valid) begin
            s_d.st = ((base != '0) ? SW'(1) : '0) | new_bits;
        end else begin
            s_d.st = base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_q = s_q.st;

    assert_fault_marks_R2: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> (st_q[AV_BIT] && st_q[FT_LSB +: FT_W] == FT_ACCESS_ERR));

    assert_overflow_mark_R3: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !clr && st_q != '0) |=> st_q[OVF_BIT]);

    assert_clear_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && clr) |=> !st_q[OVF_BIT]);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !flt_valid) |=> (st_q == '0));

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !flt_valid) |=> $stable(st_q));

endmodule

// File: rtl/mmu_flt_addr.sv
module mmu_flt_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flt_valid,
    input  logic [AW-1:0] flt_addr,
    output logic [AW-1:0] addr_q
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } ad_state_t;

    ad_state_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (flt_valid) begin
            a_d.addr = flt_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign addr_q = a_q.addr;

    assert_addr_capture_R5: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> (addr_q == $past(flt_addr)));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !flt_valid |=> $stable(addr_q));

endmodule

// File: rtl/mmu_flt_trap.sv
module mmu_flt_trap (
    input  logic clk,
    input  logic rst,
    input  logic flt_valid,
    input  logic ctl_enable,
    input  logic ctl_nofault,
    output logic trap_q
);

    typedef struct packed {
        logic trap;
    } tr_state_t;

    tr_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        t_d.trap = flt_valid && ctl_enable && !ctl_nofault;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign trap_q = t_q.trap;

    assert_trap_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && ctl_enable && !ctl_nofault) |=> trap_q);

    assert_trap_gated_R6: assert property (@(posedge clk) disable iff (rst)
        !(flt_valid && ctl_enable && !ctl_nofault) |=> !trap_q);

endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
    import mmu_flt_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 32,
    localparam int DW = (AW > SW) ? AW : SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flt_valid,
    input  logic [AW-1:0] flt_addr,
    input  logic          flt_write,
    input  logic          flt_fetch,
    input  logic          flt_alt,
    input  logic          flt_super,
    input  logic          ctl_enable,
    input  logic          ctl_nofault,
    input  logic          rd_en,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          trap_pulse
);

    flt_qual_t     qual;
    logic          st_clr;
    logic [SW-1:0] st_q;
    logic [AW-1:0] addr_q;

    assign qual = '{write: flt_write, fetch: flt_fetch,
                    alt: flt_alt, super_mode: flt_super};
    assign st_clr = rd_en && !rd_sel;

    mmu_flt_status #(.SW(SW)) u_status (
        .clk       (clk),
        .rst       (rst),
        .flt_valid (flt_valid),
        .qual      (qual),
        .clr       (st_clr),
        .st_q      (st_q)
    );

    mmu_flt_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .flt_valid (flt_valid),
        .flt_addr  (flt_addr),
        .addr_q    (addr_q)
    );

    mmu_flt_trap u_trap (
        .clk         (clk),
        .rst         (rst),
        .flt_valid   (flt_valid),
        .ctl_enable  (ctl_enable),
        .ctl_nofault (ctl_nofault),
        .trap_q      (trap_pulse)
    );

    // Read data comes straight from the registers in the cycle of the read.
    always_comb begin
        if (!rd_en) begin
            rd_data = '0;
        end else if (rd_sel) begin
            rd_data = DW'(addr_q);
        end else begin
            rd_data = DW'(st_q);
        end
    end

    initial begin
        assert_width_ok_R4: assert (SW >= MIN_SW);
    end

endmodule

// File: tb/mmu_fault_capture_tb.sv
module mmu_fault_capture_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 32;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flt_valid = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    logic          flt_write = 1'b0, flt_fetch = 1'b0, flt_alt = 1'b0, flt_super = 1'b0;
    logic          ctl_enable = 1'b0, ctl_nofault = 1'b0;
    logic          rd_en = 1'b0, rd_sel = 1'b0;
    logic [31:0]   rd_data;
    logic          trap_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_fault_capture #(.AW(AW), .SW(SW)) u_dut (
        .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_write(flt_write), .flt_fetch(flt_fetch), .flt_alt(flt_alt),
        .flt_super(flt_super), .ctl_enable(ctl_enable), .ctl_nofault(ctl_nofault),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .trap_pulse(trap_pulse)
    );

    // {write, fetch, alt, super, enable, nofault}, address, expected status, expected trap
    localparam logic [70:0] VEC [NV] = '{
        {6'b000010, 32'h1000_0000, 32'h0000_0016, 1'b1},
        {6'b100010, 32'h2000_0004, 32'h0000_0096, 1'b1},
        {6'b010100, 32'h3000_0008, 32'h0000_0076, 1'b0},
        {6'b001011, 32'h4000_000C, 32'h0001_0016, 1'b0},
        {6'b101110, 32'h5555_AAAA, 32'h0001_00B6, 1'b1},
        {6'b111101, 32'hDEAD_BEEF, 32'h0001_00F6, 1'b0},
        {6'b000110, 32'hFFFF_FFFC, 32'h0000_0036, 1'b1},
        {6'b011010, 32'h0000_0000, 32'h0001_0056, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic drive_fault(input logic [5:0] q, input logic [31:0] a);
        {flt_write, flt_fetch, flt_alt, flt_super, ctl_enable, ctl_nofault} = q;
        flt_addr = a;
        flt_valid = 1'b1;
    endtask

    task automatic idle_inputs();
        flt_valid = 1'b0;
        rd_en = 1'b0;
        rd_sel = 1'b0;
    endtask

    // Read at a falling edge; sample mid-cycle; the read retires at the next rising edge.
    task automatic read_reg(input logic sel, input string req, input logic [31:0] exp);
        @(negedge clk);
        idle_inputs();
        rd_en = 1'b1;
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 trap after reset", {31'b0, trap_pulse}, 32'h0);
        read_reg(1'b0, "R1 status after reset", 32'h0);
        read_reg(1'b1, "R1 address after reset", 32'h0);

        // Table walk: each fault lands on a cleared status register.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            drive_fault(VEC[i][70:65], VEC[i][64:33]);
            @(negedge clk);
            idle_inputs();
            #1;
            check("R6 trap gating", {31'b0, trap_pulse}, {31'b0, VEC[i][0]});
            rd_en = 1'b1;
            rd_sel = 1'b0;
            #1;
            check("R2 R4 status word", rd_data, VEC[i][32:1]);
            @(negedge clk);
            rd_sel = 1'b1;
            #1;
            check("R6 trap one cycle", {31'b0, trap_pulse}, 32'h0);
            check("R5 address capture", rd_data, VEC[i][64:33]);
        end

        // Overflow: two faults with no read in between.
        @(negedge clk);
        idle_inputs();
        drive_fault(6'b100010, 32'hA000_0000);
        @(negedge clk);
        drive_fault(6'b010010, 32'hB000_0000);
        @(negedge clk);
        idle_inputs();
        #1;
        check("R6 back-to-back trap", {31'b0, trap_pulse}, 32'h1);
        read_reg(1'b1, "R5 last address kept", 32'hB000_0000);
        read_reg(1'b0, "R3 overflow word", 32'h0000_0057);

        // Fault coincident with status read on a nonzero register.
        @(negedge clk);
        idle_inputs();
        drive_fault(6'b100011, 32'hC000_0000);
        @(negedge clk);
        drive_fault(6'b001011, 32'hD000_0000);
        rd_en = 1'b1;
        rd_sel = 1'b0;
        #1;
        check("R8 read returns old value", rd_data, 32'h0000_0096);
        read_reg(1'b0, "R8 fault wins over clear", 32'h0001_0016);
        read_reg(1'b0, "R7 status cleared by read", 32'h0);
        read_reg(1'b1, "R7 address read", 32'hD000_0000);
        read_reg(1'b1, "R7 address read has no side effect", 32'hD000_0000);

        // Hold while idle.
        @(negedge clk);
        idle_inputs();
        drive_fault(6'b000110, 32'h1234_5678);
        @(negedge clk);
        idle_inputs();
        repeat (5) @(negedge clk);
        read_reg(1'b1, "R9 address holds", 32'h1234_5678);
        read_reg(1'b0, "R9 status holds", 32'h0000_0036);

        // Reset in the middle of activity.
        @(negedge clk);
        idle_inputs();
        drive_fault(6'b100010, 32'h7777_0000);
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 trap cleared by reset", {31'b0, trap_pulse}, 32'h0);
        read_reg(1'b0, "R1 status cleared by reset", 32'h0);
        read_reg(1'b1, "R1 address cleared by reset", 32'h0);

        @(negedge clk);
        idle_inputs();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule